// File: doc/BRIEF.md
# Bit-Masked GPIO Port Register File

This block is an eight-line general-purpose I/O port that sits behind a byte-wide memory-mapped register bus. The bus has an address, a write strobe, write data and registered read data. Software sets each pin's direction in a direction register, drives output pins from an output data register, and reads input pins after they pass through a clock-domain synchronizer. A third register holds a per-pin interrupt enable pattern. The block only stores that pattern and hands it to the neighbouring edge/level detector.

Pin data is not reached through a single address. It sits in a window of addresses at the bottom of the map, and address bits [9:2] of each data access act as a per-pin mask. A store changes only the pins whose mask bit is set. A load returns zero in every unmasked position. Software can therefore set, clear or sample any subset of pins in one bus access, with no read-modify-write sequence and no lock.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is high, and on the first cycle after it, pin_oe, pin_out, irq_en and bus_rdata are all 0, so every pin starts as an input.
- R2: A write to offset 0x400 (the full 12-bit address must match) loads the direction register. Reading offset 0x400 returns it, and pin_oe equals it bit for bit (1 = output, 0 = input).
- R3: A write to any offset below 0x400 is a data write with mask = address bits [9:2] (bit 2 selects pin 0). Address bits [1:0] are ignored. For each pin that is an output and whose mask bit is 1, the data register bit takes the matching write data bit. All other data bits keep their value, and pin_out equals the data register.
- R4: A data write to a pin that is configured as an input is ignored. When that pin later becomes an output, it drives the value the data register held before that write, until it is written again.
- R5: A data read (offset below 0x400) returns 0 in every bit position whose mask bit (address bits [9:2]) is 0.
- R6: In masked positions, a data read returns the data register bit for output pins and the synchronized pin level for input pins.
- R7: An input pin change is seen through a two-stage synchronizer. When pin_in changes just after a rising edge, a data read reports the old level after the first and second edges and the new level after the third edge.
- R8: A write to offset 0x410 loads the interrupt enable register. It reads back as written and drives irq_en.
- R9: Any other offset is unmapped. It reads as 0, and writes to it change none of direction, data or interrupt enable.
- R10: bus_rdata is registered. It shows the value selected by the address present at one rising edge from that edge on. A write in the same cycle is not yet visible in that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wen | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous edge |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin (1 = drive) |
| irq_en | output | 8 | Per-pin interrupt enable pattern for the detector |

## Verification
Register writes land on the edge that samples the strobe, so pin_out, pin_oe and irq_en are checked at the next falling edge. Read data is due one edge after the address is applied and is sampled at the falling edge after that edge. A pin change needs three edges to reach bus_rdata: two synchronizer stages and the read register. The directed latency test samples at the second and third edges on purpose. The random phase waits three full cycles after every pin change before it reads, so the model's pin value is already valid.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned DEF_PINS   = 8;
    localparam int unsigned DEF_ADDR_W = 12;
    localparam int unsigned DEF_SYNC   = 2;

    // Which register an access selects
    typedef enum logic [1:0] {
        RGN_DATA = 2'd0,
        RGN_DIR  = 2'd1,
        RGN_IEN  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    // Decoded bus access
    typedef struct packed {
        region_e region;
        logic    wr;
    } acc_t;

    function automatic logic writes_to(acc_t a, region_e r);
        return a.wr && (a.region == r);
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS = DEF_PINS,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] DIR_OFS = 'h400,
    parameter logic [ADDR_W-1:0] IEN_OFS = 'h410
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    output acc_t              acc,
    output logic [N_PINS-1:0] mask
);
    localparam int unsigned MASK_LO = 2;
    localparam int unsigned MASK_HI = N_PINS + MASK_LO - 1;

    logic in_window;

    // The data window is every address whose bits above the mask are zero
    assign in_window = (addr[ADDR_W-1:MASK_HI+1] == '0);
    assign mask      = addr[MASK_HI:MASK_LO];

    always_comb begin
        acc.wr = wen;
        if (in_window)
            acc.region = RGN_DATA;
        else if (addr == DIR_OFS)
            acc.region = RGN_DIR;
        else if (addr == IEN_OFS)
            acc.region = RGN_IEN;
        else
            acc.region = RGN_NONE;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned N_PINS = gpio_pkg::DEF_PINS,
    parameter int unsigned STAGES = gpio_pkg::DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] raw,
    output logic [N_PINS-1:0] synced
);
    logic [N_PINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign synced = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS = DEF_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [N_PINS-1:0] mask,
    input  logic [N_PINS-1:0] wdata,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] out_q,
    output logic [N_PINS-1:0] ien_q
);
    logic dir_we, ien_we, dat_we;

    assign dir_we = writes_to(acc, RGN_DIR);
    assign ien_we = writes_to(acc, RGN_IEN);
    assign dat_we = writes_to(acc, RGN_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            ien_q <= '0;
        end else begin
            if (dir_we) dir_q <= wdata;
            if (ien_we) ien_q <= wdata;
        end
    end

    // Per-pin data flop: updated only for masked pins that are outputs
    for (genvar i = 0; i < N_PINS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                out_q[i] <= 1'b0;
            else if (dat_we && mask[i] && dir_q[i])
                out_q[i] <= wdata[i];
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS = DEF_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [N_PINS-1:0] mask,
    input  logic [N_PINS-1:0] dir_q,
    input  logic [N_PINS-1:0] out_q,
    input  logic [N_PINS-1:0] ien_q,
    input  logic [N_PINS-1:0] pins_s,
    output logic [N_PINS-1:0] rdata
);
    logic [N_PINS-1:0] level;
    logic [N_PINS-1:0] rd_nxt;

    // Outputs report what is driven, inputs report what is sampled
    assign level = (dir_q & out_q) | (~dir_q & pins_s);

    always_comb begin
        unique case (acc.region)
            RGN_DATA: rd_nxt = level & mask;
            RGN_DIR:  rd_nxt = dir_q;
            RGN_IEN:  rd_nxt = ien_q;
            default:  rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_nxt;
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS = DEF_PINS,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC,
    parameter logic [ADDR_W-1:0] DIR_OFS = 'h400,
    parameter logic [ADDR_W-1:0] IEN_OFS = 'h410
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] irq_en
);
    acc_t              acc;
    logic [N_PINS-1:0] mask;
    logic [N_PINS-1:0] dir_q, out_q, ien_q, pins_s;

    gpio_addr_decode #(
        .N_PINS(N_PINS), .ADDR_W(ADDR_W),
        .DIR_OFS(DIR_OFS), .IEN_OFS(IEN_OFS)
    ) u_dec (
        .addr(bus_addr), .wen(bus_wen), .acc(acc), .mask(mask)
    );

    gpio_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(pin_in), .synced(pins_s)
    );

    gpio_ctrl_regs #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .rst(rst), .acc(acc), .mask(mask), .wdata(bus_wdata),
        .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q)
    );

    gpio_read_mux #(.N_PINS(N_PINS)) u_rd (
        .clk(clk), .rst(rst), .acc(acc), .mask(mask),
        .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q), .pins_s(pins_s),
        .rdata(bus_rdata)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq_en  = ien_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned N_PINS = gpio_pkg::DEF_PINS,
    parameter int unsigned ADDR_W = gpio_pkg::DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] DIR_OFS = 'h400,
    parameter logic [ADDR_W-1:0] IEN_OFS = 'h410
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wen,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] bus_rdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic [N_PINS-1:0] irq_en
);
    logic              win, is_dir, is_ien, unmapped;
    logic [N_PINS-1:0] amask;

    assign win      = (bus_addr >> (N_PINS + 2)) == '0;
    assign amask    = bus_addr[N_PINS+1:2];
    assign is_dir   = (bus_addr == DIR_OFS);
    assign is_ien   = (bus_addr == IEN_OFS);
    assign unmapped = !win && !is_dir && !is_ien;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && irq_en == '0 && bus_rdata == '0)); // R1

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && is_dir) |=> (pin_oe == $past(bus_wdata))); // R2

    AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && win) |=> (((pin_out ^ $past(pin_out)) & ~$past(amask)) == '0)); // R3

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(bus_wen && win) |=> $stable(pin_out)); // R3

    AST_INPUT_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && win) |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0)); // R4

    AST_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
        win |=> ((bus_rdata & ~$past(amask)) == '0)); // R5

    AST_IEN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && is_ien) |=> (irq_en == $past(bus_wdata))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        unmapped |=> (bus_rdata == '0)); // R9

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && unmapped) |=> ($stable(pin_oe) && $stable(irq_en) && $stable(pin_out))); // R9

    AST_DIR_READ: assert property (@(posedge clk) disable iff (rst)
        (is_dir && !bus_wen && $stable(pin_oe)) |=> (bus_rdata == pin_oe)); // R10

endmodule

bind gpio_port_regs gpio_port_chk #(
    .N_PINS(N_PINS), .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS), .IEN_OFS(IEN_OFS)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_en(irq_en)
);

// File: tb/sim_gpio_port_regs.sv
`timescale 1ns/1ps
module sim_gpio_port_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe, irq_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model
    logic [7:0] m_dir = '0, m_out = '0, m_ien = '0;

    always #4 clk = ~clk;

    gpio_port_regs u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_en(irq_en)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_data(logic [11:0] a);
        logic [7:0] msk = a[9:2];
        return msk & ((m_dir & m_out) | (~m_dir & pin_in));
    endfunction

    function automatic logic [11:0] unmapped_addr(int k);
        case (k)
            0: return 12'h404;
            1: return 12'h408;
            2: return 12'h40C;
            3: return 12'h414;
            4: return 12'h401;
            5: return 12'h800;
            default: return 12'hFFC;
        endcase
    endfunction

    task automatic bus_write(logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wen = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic model_data_write(logic [11:0] a, logic [7:0] d);
        logic [7:0] en = a[9:2] & m_dir;
        m_out = (m_out & ~en) | (d & en);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int seed_v;
        seed_v = $urandom(32'h5EED_0042);

        repeat (3) @(negedge clk);
        // R1: state while and right after reset
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        check("R1 ien", irq_en, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        rst = 1'b0;
        bus_read(12'h400, rd);
        check("R1 dir readback", rd, 8'h00);

        // R4: writes while all pins are inputs are dropped
        bus_write(12'h3FC, 8'hFF);
        check("R4 write to inputs", pin_out, 8'h00);
        bus_write(12'h400, 8'hFF); m_dir = 8'hFF;
        check("R2 oe", pin_oe, 8'hFF);
        check("R4 old value after switch", pin_out, 8'h00);

        // R3: full and single-bit masked writes
        bus_write(12'h3FC, 8'hA5); model_data_write(12'h3FC, 8'hA5);
        check("R3 full write", pin_out, 8'hA5);
        bus_write(12'h007, 8'h00); model_data_write(12'h007, 8'h00);
        check("R3 clear pin0, low bits ignored", pin_out, 8'hA4);
        bus_write(12'h200, 8'hFF); model_data_write(12'h200, 8'hFF);
        check("R3 set pin7 only", pin_out, 8'hA4);
        bus_write(12'h040, 8'hFF); model_data_write(12'h040, 8'hFF);
        check("R3 set pin4 only", pin_out, 8'hB4);

        // R5: unmasked positions read 0
        bus_read(12'h03C, rd);
        check("R5 masked read", rd, 8'h04);
        bus_read(12'h000, rd);
        check("R5 zero mask", rd, 8'h00);

        // R6: mixed directions
        bus_write(12'h400, 8'h0F); m_dir = 8'h0F;
        @(negedge clk); pin_in = 8'h9C;
        repeat (3) @(negedge clk);
        bus_read(12'h3FC, rd);
        check("R6 mixed read", rd, 8'h94);

        // R4: stale input write then switch to output keeps old bit
        bus_write(12'h200, 8'h00); model_data_write(12'h200, 8'h00);
        bus_write(12'h400, 8'h8F); m_dir = 8'h8F;
        check("R4 pin7 keeps old", pin_out, 8'hB4);

        // R7: synchronizer latency, pin3 high->low region is output; use pin6
        bus_write(12'h400, 8'h00); m_dir = 8'h00;
        @(negedge clk);
        pin_in = 8'h00; bus_addr = 12'h100;
        repeat (4) @(negedge clk);
        pin_in = 8'h40;
        @(negedge clk);
        check("R7 after edge 1", bus_rdata, 8'h00);
        @(negedge clk);
        check("R7 after edge 2", bus_rdata, 8'h00);
        @(negedge clk);
        check("R7 after edge 3", bus_rdata, 8'h40);

        // R8: interrupt enable
        bus_write(12'h410, 8'h5A); m_ien = 8'h5A;
        check("R8 irq_en", irq_en, 8'h5A);
        bus_read(12'h410, rd);
        check("R8 readback", rd, 8'h5A);

        // R9: unmapped offsets
        for (int k = 0; k < 7; k++) begin
            bus_write(unmapped_addr(k), 8'hC3);
            check("R9 oe kept", pin_oe, m_dir);
            check("R9 ien kept", irq_en, m_ien);
            check("R9 out kept", pin_out, m_out);
            bus_read(unmapped_addr(k), rd);
            check("R9 reads 0", rd, 8'h00);
        end

        // R10: write and read same cycle shows old value, next read new
        @(negedge clk);
        bus_addr = 12'h410; bus_wdata = 8'h11; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
        check("R10 same-cycle read is old", bus_rdata, 8'h5A);
        m_ien = 8'h11;
        @(negedge clk);
        check("R10 next read new", bus_rdata, 8'h11);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 7);
            logic [7:0]  d = 8'($urandom_range(0, 255));
            logic [11:0] a = 12'(($urandom_range(0, 255) << 2) | $urandom_range(0, 3));
            case (op)
                0: begin
                    bus_write(a, d); model_data_write(a, d);
                    check("R3 random write", pin_out, m_out);
                end
                1: begin
                    bus_write(12'h400, d); m_dir = d;
                    check("R2 random dir", pin_oe, m_dir);
                end
                2: begin
                    bus_write(12'h410, d); m_ien = d;
                    check("R8 random ien", irq_en, m_ien);
                end
                3, 4: begin
                    bus_read(a, rd);
                    check("R6 random data read", rd, exp_data(a));
                end
                5: begin
                    bus_read(12'h400, rd);
                    check("R2 random dir read", rd, m_dir);
                    bus_read(12'h410, rd);
                    check("R8 random ien read", rd, m_ien);
                end
                6: begin
                    bus_write(unmapped_addr($urandom_range(0, 6)), d);
                    check("R9 random oe", pin_oe, m_dir);
                    check("R9 random out", pin_out, m_out);
                end
                default: begin
                    @(negedge clk); pin_in = d;
                    repeat (3) @(negedge clk);
                end
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule